// File: doc/BRIEF.md
# Flash Page Byte-Patch Sequencer

This block is a host-side controller that rewrites a run of bytes inside one page of a serial flash while leaving every other byte of that page intact. A client hands it a page number, a starting byte offset within the page, a byte count and a buffer choice. It then supplies the new bytes on a streaming port. The sequencer drives a byte-level SPI shifter through three device commands. The first copies the whole page into one of the device's two on-chip SRAM buffers. The second overwrites the chosen bytes in that buffer. The third programs the buffer back into the page; the device erases the page as part of this command.

The device performs the copy and the program on its own clock. After each of them the sequencer keeps chip select low and reads the status byte repeatedly until the ready bit is set. If the device stays busy for more status bytes than a configurable limit, the operation ends with an error. A request whose byte range does not fit inside one 264-byte page is rejected at once and causes no bus traffic.

The shifter handshake is one byte at a time. The sequencer raises `spi_go` for one cycle with the byte on `spi_tx`. The shifter answers with a one-cycle `spi_ack` when that byte has been exchanged, and presents the byte it received on `spi_rx` in the same cycle. Chip select is driven directly by the sequencer.

Top module: `pg_rmw_seq`

States:
- `S_IDLE`: waits for a request; `req_ready` is high.
- `S_REJECT`: a one-cycle error pulse for an out-of-range request.
- `S_OPC`: sends the command opcode.
- `S_ADDR`: sends the three address bytes.
- `S_DATA`: sends the patch bytes during the buffer write.
- `S_GAP`: chip select is high between commands.
- `S_POLL_OPC`: sends the status opcode.
- `S_POLL_RD`: clocks out dummy bytes and tests the returned status.
- `S_DONE`: a one-cycle success pulse.
- `S_FAIL`: a one-cycle error pulse after a poll time-out.

Transitions:
- `S_IDLE` goes to `S_REJECT` or to `S_OPC` when a request is accepted.
- `S_OPC` goes to `S_ADDR` on the opcode ack.
- `S_ADDR` goes to `S_DATA` after the third address ack of the write command, and to `S_GAP` after the third address ack of the copy or program command.
- `S_DATA` goes to `S_GAP` after the last patch byte.
- `S_GAP` goes to `S_POLL_OPC` after the copy or the program. It goes to `S_OPC` with the next phase after the copy's poll and after the write. It goes to `S_DONE` after the program's poll.
- `S_POLL_OPC` goes to `S_POLL_RD`.
- `S_POLL_RD` goes to `S_GAP` on a ready status, and to `S_FAIL` when the limit is reached.
- `S_REJECT`, `S_DONE` and `S_FAIL` go to `S_IDLE`.

## Requirements
- R1: After reset `req_ready` is 1, `spi_cs_n` is 1, and `spi_go`, `done` and `error` are 0.
- R2: A request with length 0, or with offset plus length greater than 264, gives exactly one `error` pulse and no `done`. It drives `spi_go` never and keeps `spi_cs_n` high, and it takes no byte from the write stream.
- R3: The first command is opcode 0x53 (buffer select 0) or 0x55 (buffer select 1). It is followed by three address bytes, most significant byte first. Together they form the 24-bit value {5 zero bits, page[9:0], 9 zero bits}.
- R4: After the copy command and after the program command, a status command is sent: opcode 0x57 followed by dummy bytes 0x00. Dummy bytes continue in the same chip-select frame until a returned byte has bit 7 set. The other status bits have no effect.
- R5: The write command is opcode 0x84 (buffer 0) or 0x87 (buffer 1). It is followed by the address {15 zero bits, offset[8:0]}, most significant byte first, and then exactly `len` bytes taken from the stream in arrival order.
- R6: The program command is opcode 0x83 (buffer 0) or 0x86 (buffer 1) with the same address as R3. Its status poll ends with one `done` pulse and no `error`.
- R7: Each command has its own chip-select frame. Between frames, `spi_cs_n` stays high for at least `GAP_CYCLES` cycles, and `spi_go` is asserted only while `spi_cs_n` is low.
- R8: If `POLL_LIMIT` consecutive status bytes all show busy, the operation ends with one `error` pulse and chip select is released. No further command of that request is sent, and the next request is served normally.
- R9: `req_ready` is high only while no operation is in progress and chip select is high. A request presented during an operation has no effect on that operation's bus traffic.
- R10: At most one byte is outstanding: `spi_go` is never asserted between a previous `spi_go` and its `spi_ack`.
- R11: `done` and `error` are never high together and each lasts exactly one cycle per operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer idle, request accepted when both high |
| req_page | input | 10 | Target page number |
| req_offset | input | 9 | First byte to replace within the page |
| req_len | input | 9 | Number of bytes to replace |
| req_buf | input | 1 | Device buffer choice (0 or 1) |
| wr_valid | input | 1 | Patch byte available |
| wr_ready | output | 1 | Patch byte taken when both high |
| wr_data | input | 8 | Patch byte |
| spi_cs_n | output | 1 | Device chip select, active low |
| spi_go | output | 1 | Start shifting `spi_tx` (one-cycle pulse) |
| spi_tx | output | 8 | Byte to shift out, valid with `spi_go` |
| spi_ack | input | 1 | Shifter finished the outstanding byte |
| spi_rx | input | 8 | Byte shifted in, valid with `spi_ack` |
| done | output | 1 | Successful completion pulse |
| error | output | 1 | Rejection or poll time-out pulse |

## Verification
The assertions assume that the shifter returns exactly one `spi_ack` for every `spi_go`, never one unprompted, and some cycles after the go. They also assume that the stream offers patch bytes only while a request that needs them is running. The bench shifter model pulses its ack a fixed three cycles after each go. It loads the write stream with exactly the request's byte count before issuing the request. A stray request is raised only while `req_ready` is low, and it is withdrawn before the running operation can finish.

// File: rtl/rmw_pkg.sv
package rmw_pkg;

    localparam int PAGE_W     = 10;
    localparam int OFF_W      = 9;
    localparam int PAGE_SIZE  = 264;
    localparam int ADDR_BYTES = 3;
    localparam int ADDR_W     = ADDR_BYTES * 8;

    localparam logic [7:0] OP_COPY_B0   = 8'h53;
    localparam logic [7:0] OP_COPY_B1   = 8'h55;
    localparam logic [7:0] OP_WRITE_B0  = 8'h84;
    localparam logic [7:0] OP_WRITE_B1  = 8'h87;
    localparam logic [7:0] OP_PROG_B0   = 8'h83;
    localparam logic [7:0] OP_PROG_B1   = 8'h86;
    localparam logic [7:0] OP_STATUS    = 8'h57;

    typedef enum logic [3:0] {
        S_IDLE,
        S_REJECT,
        S_OPC,
        S_ADDR,
        S_DATA,
        S_GAP,
        S_POLL_OPC,
        S_POLL_RD,
        S_DONE,
        S_FAIL
    } seq_state_t;

    typedef enum logic [1:0] {
        PH_COPY,
        PH_WRITE,
        PH_PROG
    } seq_phase_t;

    typedef enum logic [1:0] {
        TX_OPC,
        TX_ADDR,
        TX_DATA,
        TX_DUMMY
    } tx_sel_t;

endpackage

// File: rtl/rmw_req_check.sv
module rmw_req_check #(
    parameter int OFFW  = 9,
    parameter int LIMIT = 264
) (
    input  logic [OFFW-1:0] offset,
    input  logic [OFFW-1:0] len,
    output logic            bad
);
    localparam int SUM_W = OFFW + 1;

    logic [SUM_W-1:0] span_end;

    always_comb begin
        span_end = {1'b0, offset} + {1'b0, len};
        bad      = (len == '0) || (span_end > SUM_W'(LIMIT));
    end
endmodule

// File: rtl/rmw_opcode_sel.sv
module rmw_opcode_sel import rmw_pkg::*; (
    input  seq_phase_t  phase,
    input  logic        polling,
    input  logic        buf_sel,
    output logic [7:0]  opcode
);
    always_comb begin
        if (polling) begin
            opcode = OP_STATUS;
        end else begin
            unique case (phase)
                PH_COPY:  opcode = buf_sel ? OP_COPY_B1  : OP_COPY_B0;
                PH_WRITE: opcode = buf_sel ? OP_WRITE_B1 : OP_WRITE_B0;
                PH_PROG:  opcode = buf_sel ? OP_PROG_B1  : OP_PROG_B0;
                default:  opcode = OP_STATUS;
            endcase
        end
    end
endmodule

// File: rtl/rmw_tx_mux.sv
module rmw_tx_mux import rmw_pkg::*; #(
    parameter int NB = 3,
    parameter int IW = $clog2(NB)
) (
    input  tx_sel_t           sel,
    input  logic [7:0]        opcode,
    input  logic [NB*8-1:0]   addr,
    input  logic [IW-1:0]     aidx,
    input  logic [7:0]        data,
    output logic [7:0]        tx
);
    localparam int SLOTS = 2 ** IW;

    logic [7:0] addr_byte [SLOTS];

    // Slot 0 carries the most significant address byte.
    for (genvar g = 0; g < SLOTS; g++) begin : g_slot
        if (g < NB) begin : g_live
            assign addr_byte[g] = addr[(NB-1-g)*8 +: 8];
        end else begin : g_pad
            assign addr_byte[g] = 8'h00;
        end
    end

    always_comb begin
        unique case (sel)
            TX_OPC:   tx = opcode;
            TX_ADDR:  tx = addr_byte[aidx];
            TX_DATA:  tx = data;
            default:  tx = 8'h00;
        endcase
    end
endmodule

// File: rtl/pg_rmw_seq.sv
module pg_rmw_seq import rmw_pkg::*; #(
    parameter int         POLL_LIMIT = 4096,
    parameter int         GAP_CYCLES = 2,
    parameter logic [7:0] READY_MASK = 8'h80
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    output logic                req_ready,
    input  logic [PAGE_W-1:0]   req_page,
    input  logic [OFF_W-1:0]    req_offset,
    input  logic [OFF_W-1:0]    req_len,
    input  logic                req_buf,
    input  logic                wr_valid,
    output logic                wr_ready,
    input  logic [7:0]          wr_data,
    output logic                spi_cs_n,
    output logic                spi_go,
    output logic [7:0]          spi_tx,
    input  logic                spi_ack,
    input  logic [7:0]          spi_rx,
    output logic                done,
    output logic                error
);
    localparam int POLL_W = $clog2(POLL_LIMIT + 1);
    localparam int GAP_W  = $clog2(GAP_CYCLES + 1);
    localparam int AIDX_W = $clog2(ADDR_BYTES);
    localparam int PAD_W  = ADDR_W - PAGE_W - OFF_W;

    seq_state_t          state, state_n, gap_target;
    seq_phase_t          phase;
    logic                polled;
    logic                inflight;
    logic [PAGE_W-1:0]   page_q;
    logic [OFF_W-1:0]    off_q;
    logic [OFF_W-1:0]    len_q;
    logic                buf_q;
    logic [OFF_W-1:0]    idx;
    logic [GAP_W-1:0]    gap_cnt;
    logic [POLL_W-1:0]   poll_cnt;

    logic                req_bad;
    logic                last_addr, last_data, gap_end, poll_last, dev_ready;
    logic [ADDR_W-1:0]   addr_word;
    logic [7:0]          opcode;
    tx_sel_t             tx_sel;

    rmw_req_check #(.OFFW(OFF_W), .LIMIT(PAGE_SIZE)) u_check (
        .offset (req_offset),
        .len    (req_len),
        .bad    (req_bad)
    );

    rmw_opcode_sel u_opc (
        .phase   (phase),
        .polling (state == S_POLL_OPC),
        .buf_sel (buf_q),
        .opcode  (opcode)
    );

    rmw_tx_mux #(.NB(ADDR_BYTES), .IW(AIDX_W)) u_mux (
        .sel    (tx_sel),
        .opcode (opcode),
        .addr   (addr_word),
        .aidx   (idx[AIDX_W-1:0]),
        .data   (wr_data),
        .tx     (spi_tx)
    );

    always_comb begin
        last_addr = (idx == OFF_W'(ADDR_BYTES - 1));
        last_data = (idx == len_q - 1'b1);
        gap_end   = (gap_cnt == GAP_W'(GAP_CYCLES - 1));
        poll_last = (poll_cnt == POLL_W'(POLL_LIMIT - 1));
        dev_ready = |(spi_rx & READY_MASK);
        if (phase == PH_WRITE) begin
            addr_word = {{(ADDR_W - OFF_W){1'b0}}, off_q};
        end else begin
            addr_word = {{PAD_W{1'b0}}, page_q, {OFF_W{1'b0}}};
        end
    end

    // Where the inter-command gap leads.
    always_comb begin
        unique case (phase)
            PH_COPY:  gap_target = polled ? S_OPC  : S_POLL_OPC;
            PH_WRITE: gap_target = S_OPC;
            PH_PROG:  gap_target = polled ? S_DONE : S_POLL_OPC;
            default:  gap_target = S_FAIL;
        endcase
    end

    always_comb begin
        state_n = state;
        unique case (state)
            S_IDLE:     if (req_valid) state_n = req_bad ? S_REJECT : S_OPC;
            S_REJECT:   state_n = S_IDLE;
            S_OPC:      if (spi_ack) state_n = S_ADDR;
            S_ADDR:     if (spi_ack && last_addr)
                            state_n = (phase == PH_WRITE) ? S_DATA : S_GAP;
            S_DATA:     if (spi_ack && last_data) state_n = S_GAP;
            S_GAP:      if (gap_end) state_n = gap_target;
            S_POLL_OPC: if (spi_ack) state_n = S_POLL_RD;
            S_POLL_RD:  if (spi_ack) begin
                            if (dev_ready)      state_n = S_GAP;
                            else if (poll_last) state_n = S_FAIL;
                        end
            S_DONE:     state_n = S_IDLE;
            S_FAIL:     state_n = S_IDLE;
            default:    state_n = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_n;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase    <= PH_COPY;
            polled   <= 1'b0;
            inflight <= 1'b0;
            page_q   <= '0;
            off_q    <= '0;
            len_q    <= '0;
            buf_q    <= 1'b0;
            idx      <= '0;
            gap_cnt  <= '0;
            poll_cnt <= '0;
        end else begin
            if (spi_go)       inflight <= 1'b1;
            else if (spi_ack) inflight <= 1'b0;

            unique case (state)
                S_IDLE: if (req_valid) begin
                    page_q <= req_page;
                    off_q  <= req_offset;
                    len_q  <= req_len;
                    buf_q  <= req_buf;
                    phase  <= PH_COPY;
                    polled <= 1'b0;
                    idx    <= '0;
                end
                S_OPC:  if (spi_ack) idx <= '0;
                S_ADDR: if (spi_ack) idx <= last_addr ? '0 : idx + 1'b1;
                S_DATA: if (spi_ack) idx <= idx + 1'b1;
                S_GAP: begin
                    if (gap_end) begin
                        gap_cnt <= '0;
                        if (gap_target == S_OPC) begin
                            phase  <= (phase == PH_COPY) ? PH_WRITE : PH_PROG;
                            polled <= 1'b0;
                            idx    <= '0;
                        end
                    end else begin
                        gap_cnt <= gap_cnt + 1'b1;
                    end
                end
                S_POLL_OPC: if (spi_ack) poll_cnt <= '0;
                S_POLL_RD: if (spi_ack) begin
                    if (dev_ready) polled   <= 1'b1;
                    else           poll_cnt <= poll_cnt + 1'b1;
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        req_ready = 1'b0;
        spi_cs_n  = 1'b1;
        spi_go    = 1'b0;
        wr_ready  = 1'b0;
        tx_sel    = TX_OPC;
        done      = 1'b0;
        error     = 1'b0;
        unique case (state)
            S_IDLE:     req_ready = 1'b1;
            S_REJECT:   error = 1'b1;
            S_OPC, S_POLL_OPC: begin
                spi_cs_n = 1'b0;
                spi_go   = !inflight;
                tx_sel   = TX_OPC;
            end
            S_ADDR: begin
                spi_cs_n = 1'b0;
                spi_go   = !inflight;
                tx_sel   = TX_ADDR;
            end
            S_DATA: begin
                spi_cs_n = 1'b0;
                wr_ready = !inflight;
                spi_go   = !inflight && wr_valid;
                tx_sel   = TX_DATA;
            end
            S_POLL_RD: begin
                spi_cs_n = 1'b0;
                spi_go   = !inflight;
                tx_sel   = TX_DUMMY;
            end
            S_DONE:     done  = 1'b1;
            S_FAIL:     error = 1'b1;
            default: ;
        endcase
    end
endmodule

// File: rtl/rmw_seq_checker.sv
module rmw_seq_checker (
    input logic clk,
    input logic rst_n,
    input logic req_ready,
    input logic spi_cs_n,
    input logic spi_go,
    input logic spi_ack,
    input logic done,
    input logic error
);
    logic outstanding;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       outstanding <= 1'b0;
        else if (spi_go)  outstanding <= 1'b1;
        else if (spi_ack) outstanding <= 1'b0;
    end

    a_r10_single_byte: assert property (@(posedge clk) disable iff (!rst_n)
        spi_go |-> !outstanding);

    a_r7_go_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
        spi_go |-> !spi_cs_n);

    a_r7_frame_gap: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(spi_cs_n) |=> spi_cs_n);

    a_r9_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (spi_cs_n && !outstanding));

    a_r11_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && error));

    a_r11_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r11_error_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        error |=> !error);

    a_r2_end_in_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (done || error) |=> req_ready);
endmodule

bind pg_rmw_seq rmw_seq_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_ready (req_ready),
    .spi_cs_n  (spi_cs_n),
    .spi_go    (spi_go),
    .spi_ack   (spi_ack),
    .done      (done),
    .error     (error)
);

// File: tb/pg_rmw_seq_tb.sv
module pg_rmw_seq_tb;
    localparam int POLL_LIM = 8;
    localparam int GAP      = 2;
    localparam int LAT      = 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0;
    logic       req_ready;
    logic [9:0] req_page = '0;
    logic [8:0] req_offset = '0;
    logic [8:0] req_len = '0;
    logic       req_buf = 1'b0;
    logic       wr_valid;
    logic       wr_ready;
    logic [7:0] wr_data;
    logic       spi_cs_n, spi_go, spi_ack, done, error;
    logic [7:0] spi_tx, spi_rx;

    always #10 clk = ~clk;

    pg_rmw_seq #(.POLL_LIMIT(POLL_LIM), .GAP_CYCLES(GAP)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_page(req_page), .req_offset(req_offset), .req_len(req_len),
        .req_buf(req_buf),
        .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data),
        .spi_cs_n(spi_cs_n), .spi_go(spi_go), .spi_tx(spi_tx),
        .spi_ack(spi_ack), .spi_rx(spi_rx),
        .done(done), .error(error)
    );

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    // write stream source
    logic [7:0] wbuf [0:511];
    int wcnt = 0;
    int widx = 0;
    assign wr_valid = (widx < wcnt);
    assign wr_data  = wbuf[widx & 511];

    // observed bus traffic
    logic [7:0] blog [0:1023];
    int fstart [0:31];
    int nlog = 0, nf = 0;
    logic       open_f = 1'b0;
    logic [7:0] fop = 8'h00;
    int fpos = 0;
    int busy_n = 0, busy_left = 0;
    int lat_cnt = 0;
    logic [7:0] pend_rx = 8'h00;
    logic       outst = 1'b0;
    int overlap = 0;
    int done_cnt = 0, err_cnt = 0;
    int hi_run = 0, min_gap = 999, lo_cycles = 0;
    logic seen_frame = 1'b0;

    // expected traffic
    logic [7:0] eblog [0:1023];
    int efstart [0:31];
    string etag [0:31];
    int enlog = 0, enf = 0;

    always @(posedge clk) begin
        if (rst_n) begin
            if (wr_valid && wr_ready) widx <= widx + 1;
            if (done)  done_cnt = done_cnt + 1;
            if (error) err_cnt  = err_cnt + 1;
            if (spi_cs_n) begin
                hi_run = hi_run + 1;
                open_f = 1'b0;
            end else begin
                if (seen_frame && hi_run > 0 && hi_run < min_gap) min_gap = hi_run;
                hi_run = 0;
                seen_frame = 1'b1;
                lo_cycles = lo_cycles + 1;
            end
            if (spi_go) begin
                if (outst) overlap = overlap + 1;
                outst = 1'b1;
                if (!open_f) begin
                    fstart[nf & 31] = nlog;
                    nf = nf + 1;
                    open_f = 1'b1;
                    fop = spi_tx;
                    fpos = 0;
                    if (spi_tx == 8'h57) busy_left = busy_n;
                end
                blog[nlog & 1023] = spi_tx;
                nlog = nlog + 1;
                if (fop == 8'h57 && fpos > 0) begin
                    if (busy_left > 0) begin
                        pend_rx = 8'h6F;
                        busy_left = busy_left - 1;
                    end else begin
                        pend_rx = 8'h94;
                    end
                end else begin
                    pend_rx = 8'hFF;
                end
                fpos = fpos + 1;
                lat_cnt <= LAT;
            end else if (lat_cnt != 0) begin
                lat_cnt <= lat_cnt - 1;
                if (lat_cnt == 1) begin
                    spi_ack <= 1'b1;
                    spi_rx  <= pend_rx;
                    outst = 1'b0;
                end
            end
            if (!(lat_cnt == 1 && !spi_go)) spi_ack <= 1'b0;
        end else begin
            spi_ack <= 1'b0;
            spi_rx  <= 8'h00;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic clear_obs();
        nlog = 0; nf = 0; open_f = 1'b0;
        done_cnt = 0; err_cnt = 0; overlap = 0;
        hi_run = 0; min_gap = 999; lo_cycles = 0; seen_frame = 1'b0;
        enlog = 0; enf = 0;
    endtask

    task automatic efr(input string tag);
        efstart[enf] = enlog;
        etag[enf] = tag;
        enf++;
    endtask

    task automatic eb(input logic [7:0] b);
        eblog[enlog] = b;
        enlog++;
    endtask

    task automatic eaddr(input logic [23:0] a);
        eb(a[23:16]); eb(a[15:8]); eb(a[7:0]);
    endtask

    task automatic epoll(input int busy, input bit timeout);
        efr("R4");
        eb(8'h57);
        if (timeout) for (int i = 0; i < POLL_LIM; i++) eb(8'h00);
        else         for (int i = 0; i <= busy; i++)    eb(8'h00);
    endtask

    function automatic logic [23:0] page_addr(input logic [9:0] p);
        return {5'b0, p, 9'b0};
    endfunction

    task automatic build_rmw(input logic [9:0] p, input logic [8:0] off,
                             input int len, input bit b, input int busy);
        efr("R3"); eb(b ? 8'h55 : 8'h53); eaddr(page_addr(p));
        epoll(busy, 1'b0);
        efr("R5"); eb(b ? 8'h87 : 8'h84); eaddr({15'b0, off});
        for (int i = 0; i < len; i++) eb(wbuf[i]);
        efr("R6"); eb(b ? 8'h86 : 8'h83); eaddr(page_addr(p));
        epoll(busy, 1'b0);
    endtask

    function automatic int flen(input int f);
        return ((f + 1 < nf) ? fstart[f+1] : nlog) - fstart[f];
    endfunction

    function automatic int eflen(input int f);
        return ((f + 1 < enf) ? efstart[f+1] : enlog) - efstart[f];
    endfunction

    task automatic cmp_frames(input string tag);
        chk(nf == enf, tag, "frame count", nf, enf);
        for (int f = 0; f < nf && f < enf; f++) begin
            int la = flen(f);
            int le = eflen(f);
            bit ok = (la == le);
            int av = la, ev = le;
            for (int k = 0; k < la && k < le; k++) begin
                if (ok && blog[fstart[f] + k] !== eblog[efstart[f] + k]) begin
                    ok = 1'b0;
                    av = blog[fstart[f] + k];
                    ev = eblog[efstart[f] + k];
                end
            end
            chk(ok, etag[f], $sformatf("frame %0d", f), av, ev);
        end
    endtask

    task automatic issue(input logic [9:0] p, input logic [8:0] off,
                         input logic [8:0] len, input bit b);
        @(negedge clk);
        req_page = p; req_offset = off; req_len = len; req_buf = b;
        req_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic wait_end();
        int t = 0;
        while (done_cnt == 0 && err_cnt == 0 && t < 20000) begin
            @(negedge clk);
            t++;
        end
        repeat (6) @(negedge clk);
    endtask

    task automatic load_stream(input int n, input int seed);
        for (int i = 0; i < n; i++) wbuf[i] = 8'((i * 37 + seed) & 8'hFF);
        widx = 0;
        wcnt = n;
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(req_ready == 1'b1, "R1", "req_ready after reset", req_ready, 1);
        chk(spi_cs_n == 1'b1, "R1", "cs_n after reset", spi_cs_n, 1);
        chk(spi_go == 1'b0, "R1", "go after reset", spi_go, 0);
        chk(done == 1'b0 && error == 1'b0, "R1", "done/error after reset",
            {done, error}, 0);
    endtask

    task automatic t_basic();
        clear_obs();
        busy_n = 3;
        load_stream(3, 8'hA1);
        build_rmw(10'h2A5, 9'd5, 3, 1'b0, 3);
        issue(10'h2A5, 9'd5, 9'd3, 1'b0);
        wait_end();
        cmp_frames("R3");
        chk(widx == 3, "R5", "stream bytes consumed", widx, 3);
        chk(done_cnt == 1 && err_cnt == 0, "R6", "one done, no error",
            done_cnt * 16 + err_cnt, 16);
        chk(min_gap >= GAP, "R7", "min cs_n high gap", min_gap, GAP);
        chk(overlap == 0, "R10", "go while outstanding", overlap, 0);
    endtask

    task automatic t_edge_and_stray();
        clear_obs();
        busy_n = 0;
        load_stream(2, 8'h3C);
        build_rmw(10'd1023, 9'd262, 2, 1'b1, 0);
        issue(10'd1023, 9'd262, 9'd2, 1'b1);
        repeat (10) @(negedge clk);
        chk(req_ready == 1'b0, "R9", "req_ready while busy", req_ready, 0);
        req_page = 10'd7; req_offset = 9'd0; req_len = 9'd1; req_buf = 1'b0;
        req_valid = 1'b1;
        repeat (30) @(negedge clk);
        req_valid = 1'b0;
        wait_end();
        cmp_frames("R9");
        chk(done_cnt == 1 && err_cnt == 0, "R11", "single done pulse",
            done_cnt * 16 + err_cnt, 16);
        chk(min_gap >= GAP, "R7", "min cs_n high gap buffer 1", min_gap, GAP);
    endtask

    task automatic t_reject(input logic [8:0] off, input logic [8:0] len);
        clear_obs();
        load_stream(4, 8'h11);
        issue(10'd9, off, len, 1'b0);
        wait_end();
        chk(err_cnt == 1 && done_cnt == 0, "R2", "reject flags",
            err_cnt * 16 + done_cnt, 16);
        chk(nlog == 0, "R2", "bytes sent on reject", nlog, 0);
        chk(lo_cycles == 0, "R2", "cs_n low cycles on reject", lo_cycles, 0);
        chk(widx == 0, "R2", "stream bytes taken on reject", widx, 0);
    endtask

    task automatic t_timeout();
        clear_obs();
        busy_n = 100;
        load_stream(1, 8'h55);
        efr("R3"); eb(8'h53); eaddr(page_addr(10'd300));
        epoll(0, 1'b1);
        issue(10'd300, 9'd10, 9'd1, 1'b0);
        wait_end();
        cmp_frames("R8");
        chk(err_cnt == 1 && done_cnt == 0, "R8", "time-out flags",
            err_cnt * 16 + done_cnt, 16);
        chk(spi_cs_n == 1'b1, "R8", "cs_n released", spi_cs_n, 1);
        chk(widx == 0, "R8", "no write after time-out", widx, 0);
        wcnt = 0;
    endtask

    task automatic t_full_page();
        clear_obs();
        busy_n = 1;
        load_stream(264, 8'h07);
        build_rmw(10'd0, 9'd0, 264, 1'b1, 1);
        issue(10'd0, 9'd0, 9'd264, 1'b1);
        wait_end();
        cmp_frames("R5");
        chk(widx == 264, "R5", "full page bytes consumed", widx, 264);
        chk(done_cnt == 1 && err_cnt == 0, "R6", "full page done",
            done_cnt * 16 + err_cnt, 16);
        chk(overlap == 0, "R10", "go while outstanding, full page", overlap, 0);
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 150000) begin
                checks++;
                fails++;
                $display("FAIL watchdog: actual=%0d expected<150000", cyc);
                summary();
            end
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_basic();
        t_edge_and_stray();
        t_reject(9'd260, 9'd5);
        t_reject(9'd0, 9'd0);
        t_timeout();
        t_full_page();
        summary();
    end
endmodule